// File: doc/BRIEF.md
# OTP Fuse Word Burner

This block burns a run of 32-bit words into a one-time-programmable fuse array, one fuse bit per write strobe. A host gives a first word index and a word count with a one-cycle `start_i` pulse, then hands over the data words one at a time through a valid/ready pair. The block checks that the run fits inside the array. It powers up the fuse array, selects the programming test mode, waits a setup time, and then enables the array and its program path.

Every accepted word is written to its array index twice: once with the redundancy select low (main cells) and once with it high (spare cells). Each pass walks the bit positions upward from 0. For each bit the block presents the bit position and the matching data bit, waits an address setup time, raises the write strobe for a fixed width, and then holds it low for a recovery gap. After the last word it drops the array controls one per cycle in a fixed order and pulses `done`. All timings are parameters counted in system-clock cycles.

Top module: `otp_burn_seq`

## Requirements
- R1: A request with `start_idx >= TOTAL_WORDS` or `start_idx + word_cnt > TOTAL_WORDS` raises `err` for exactly one cycle, one cycle after `start_i`. `busy` stays low and no fuse-array output leaves its idle value.
- R2: An in-range request with `word_cnt == 0` raises `done` for one cycle, one cycle after `start_i`, with no fuse-array activity.
- R3: One cycle after an accepted start, `fz_dstb` and `fz_trim` read 1. At that point `fz_ce`, `fz_prog`, `fz_we`, `fz_addr`, `fz_red`, `fz_bitsel`, `fz_din` and `fz_mode` all read 0. One cycle later `fz_mode` reads 2 (the fuse-programming code, bit 1 set).
- R4: `fz_ce` rises exactly `MODE_SETUP_CYC` cycles after `fz_mode` becomes 2, and `fz_prog` rises one cycle after `fz_ce`. `fz_we` is only ever high while `fz_dstb`, `fz_trim`, `fz_ce` and `fz_prog` are 1 and `fz_mode` is 2.
- R5: Word k of a run is written with `fz_addr = start_idx + k`. Its first 32 strobes have `fz_red = 0` and its next 32 have `fz_red = 1`, so each run gives 64 strobes per word. `fz_red` is 0 again once the word is finished.
- R6: Within each pass, the strobes take `fz_bitsel` = 0, 1, ..., 31 in order, and at each strobe `fz_din` equals bit `fz_bitsel` of the word.
- R7: `fz_addr`, `fz_red`, `fz_bitsel` and `fz_din` settle exactly `ADDR_SETUP_CYC` cycles before each strobe that follows another strobe of the same word. They settle at least that long before the first strobe of a word, and they do not change while the strobe is high.
- R8: `fz_we` stays high for exactly `PULSE_CYC` cycles. Between two strobes of one word it stays low for exactly `GAP_CYC + ADDR_SETUP_CYC` cycles.
- R9: `data_ready` is high only while the array is enabled for programming and no strobe is active. A word is taken only after all 64 strobes of the previous word are finished.
- R10: After the last strobe, `fz_prog` falls `GAP_CYC` cycles after `fz_we` falls. Then `fz_ce`, `fz_mode`, `fz_trim` and `fz_dstb` fall on the next four consecutive cycles in that order, and `done` is high in the cycle `fz_dstb` falls.
- R11: `busy` is high from the cycle after an accepted start until `done`. A `start_i` that arrives while busy is ignored and does not change the run.
- R12: After reset, and throughout operation, `fz_clk` is 0. After reset, all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request pulse |
| start_idx | input | IDX_W | First word index of the run |
| word_cnt | input | IDX_W+1 | Number of words in the run |
| data_valid | input | 1 | Host has a data word |
| data_word | input | WORD_W | Word to burn |
| data_ready | output | 1 | Block takes a word this cycle if valid |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle run completion pulse |
| err | output | 1 | One-cycle out-of-range rejection pulse |
| fz_dstb | output | 1 | Array standby release (1 = awake) |
| fz_trim | output | 1 | Array trim/repair enable |
| fz_ce | output | 1 | Array chip enable |
| fz_prog | output | 1 | Array program enable |
| fz_mode | output | 2 | Array test-mode code, 2 while programming |
| fz_clk | output | 1 | Array read clock, held low |
| fz_addr | output | IDX_W | Word index |
| fz_red | output | 1 | Redundancy cell select |
| fz_bitsel | output | $clog2(WORD_W) | Bit position select |
| fz_din | output | 1 | Data bit to burn |
| fz_we | output | 1 | Write strobe |

## Verification
The hardest case to reach from the ports is a host that holds back the next word while the array sits enabled, combined with a stray `start_i` in the middle of a run. Getting there needs the data driver to wait a random number of cycles before each word, and to inject a start pulse that would be rejected if it were decoded, right after a word is taken. The run's boundary cases matter too: a run that ends exactly on the last array index, one that overruns it by one, a start just past the end, and a zero-length run. These are issued as directed requests between randomly placed runs with random data.

// File: rtl/otp_burn_pkg.sv
package otp_burn_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INIT,
    ST_MSET,
    ST_PEN,
    ST_WORD,
    ST_SETUP,
    ST_PULSE,
    ST_GAP,
    ST_SH_CE,
    ST_SH_MODE,
    ST_SH_TRIM,
    ST_SH_DSTB
  } burn_state_e;

  localparam logic [1:0] MODE_OFF     = 2'd0;
  localparam logic [1:0] MODE_PROGRAM = 2'd2;

  // true when [first, first+n) lies inside an array of 'total' words
  function automatic logic span_fits(input logic [31:0] first,
                                     input logic [31:0] n,
                                     input logic [31:0] total);
    return (first < total) && ((first + n) <= total);
  endfunction

  // load value for a phase that must last 'cycles' clocks (cycles >= 1)
  function automatic int phase_load(input int cycles);
    return (cycles > 0) ? cycles - 1 : 0;
  endfunction

endpackage

// File: rtl/otp_span_check.sv
module otp_span_check
  import otp_burn_pkg::*;
#(
  parameter int IDX_W       = 12,
  parameter int TOTAL_WORDS = 4096,
  parameter int CNT_W       = IDX_W + 1
) (
  input  logic [IDX_W-1:0] first_idx,
  input  logic [CNT_W-1:0] count,
  output logic             fits,
  output logic             empty
);

  assign fits  = span_fits(32'(first_idx), 32'(count), 32'(TOTAL_WORDS));
  assign empty = (count == '0);

endmodule

// File: rtl/otp_phase_timer.sv
module otp_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain_q <= '0;
    else if (load)            remain_q <= load_val;
    else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
  end

  assign expired = (remain_q == '0);

endmodule

// File: rtl/otp_bit_walker.sv
module otp_bit_walker #(
  parameter int WORD_W = 32,
  parameter int BIT_W  = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [BIT_W-1:0] bit_idx,
  output logic             pass,
  output logic             last_bit,
  output logic             last_pulse
);

  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(WORD_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0;
      pass    <= 1'b0;
    end else if (clr) begin
      bit_idx <= '0;
      pass    <= 1'b0;
    end else if (step) begin
      if (last_bit) begin
        bit_idx <= '0;
        pass    <= ~pass;
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  assign last_bit   = (bit_idx == TOP_BIT);
  assign last_pulse = last_bit & pass;

endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
  import otp_burn_pkg::*;
#(
  parameter int IDX_W          = 12,
  parameter int TOTAL_WORDS    = 4096,
  parameter int WORD_W         = 32,
  parameter int MODE_SETUP_CYC = 125,
  parameter int ADDR_SETUP_CYC = 125,
  parameter int PULSE_CYC      = 2500,
  parameter int GAP_CYC        = 625,
  localparam int CNT_W         = IDX_W + 1,
  localparam int BIT_W         = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [CNT_W-1:0]  word_cnt,
  input  logic              data_valid,
  input  logic [WORD_W-1:0] data_word,
  output logic              data_ready,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              fz_dstb,
  output logic              fz_trim,
  output logic              fz_ce,
  output logic              fz_prog,
  output logic [1:0]        fz_mode,
  output logic              fz_clk,
  output logic [IDX_W-1:0]  fz_addr,
  output logic              fz_red,
  output logic [BIT_W-1:0]  fz_bitsel,
  output logic              fz_din,
  output logic              fz_we
);

  localparam int MAX_A  = (MODE_SETUP_CYC > ADDR_SETUP_CYC) ? MODE_SETUP_CYC : ADDR_SETUP_CYC;
  localparam int MAX_B  = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int MAX_D  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW     = (MAX_D > 1) ? $clog2(MAX_D + 1) : 1;
  localparam logic [TW-1:0] LD_MSET  = TW'(phase_load(MODE_SETUP_CYC));
  localparam logic [TW-1:0] LD_SETUP = TW'(phase_load(ADDR_SETUP_CYC));
  localparam logic [TW-1:0] LD_PULSE = TW'(phase_load(PULSE_CYC));
  localparam logic [TW-1:0] LD_GAP   = TW'(phase_load(GAP_CYC));

  burn_state_e state_q;

  logic              span_ok, span_empty;
  logic              tmr_load, tmr_done;
  logic [TW-1:0]     tmr_val;
  logic              walk_clr, walk_step;
  logic              last_pulse, last_bit;
  logic [BIT_W-1:0]  bit_idx;
  logic              pass_q;

  logic              busy_q, done_q, err_q;
  logic              dstb_q, trim_q, ce_q, prog_q, we_q;
  logic [1:0]        mode_q;
  logic [IDX_W-1:0]  addr_q, idx_q;
  logic [CNT_W-1:0]  left_q;
  logic [WORD_W-1:0] word_q;

  // named internal events, used by the bound checker
  logic              start_go;
  logic              word_take;
  logic              phase_end;

  otp_span_check #(
    .IDX_W       (IDX_W),
    .TOTAL_WORDS (TOTAL_WORDS),
    .CNT_W       (CNT_W)
  ) u_span (
    .first_idx (start_idx),
    .count     (word_cnt),
    .fits      (span_ok),
    .empty     (span_empty)
  );

  otp_phase_timer #(
    .TW (TW)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  otp_bit_walker #(
    .WORD_W (WORD_W),
    .BIT_W  (BIT_W)
  ) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (walk_clr),
    .step       (walk_step),
    .bit_idx    (bit_idx),
    .pass       (pass_q),
    .last_bit   (last_bit),
    .last_pulse (last_pulse)
  );

  assign start_go   = (state_q == ST_IDLE) && start_i && span_ok && !span_empty;
  assign data_ready = (state_q == ST_WORD);
  assign word_take  = data_ready && data_valid;
  assign phase_end  = tmr_done;
  assign walk_clr   = start_go;
  assign walk_step  = (state_q == ST_GAP) && phase_end;

  // phase timer loading: each timed state lasts exactly its cycle count
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = LD_SETUP;
    unique case (state_q)
      ST_INIT:  begin tmr_load = 1'b1;                      tmr_val = LD_MSET;  end
      ST_WORD:  begin tmr_load = word_take;                 tmr_val = LD_SETUP; end
      ST_SETUP: begin tmr_load = phase_end;                 tmr_val = LD_PULSE; end
      ST_PULSE: begin tmr_load = phase_end;                 tmr_val = LD_GAP;   end
      ST_GAP:   begin tmr_load = phase_end && !last_pulse;  tmr_val = LD_SETUP; end
      default:  begin tmr_load = 1'b0;                      tmr_val = LD_SETUP; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      dstb_q  <= 1'b0;
      trim_q  <= 1'b0;
      ce_q    <= 1'b0;
      prog_q  <= 1'b0;
      we_q    <= 1'b0;
      mode_q  <= MODE_OFF;
      addr_q  <= '0;
      idx_q   <= '0;
      left_q  <= '0;
      word_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (!span_ok) begin
              err_q <= 1'b1;
            end else if (span_empty) begin
              done_q <= 1'b1;
            end else begin
              busy_q  <= 1'b1;
              dstb_q  <= 1'b1;
              trim_q  <= 1'b1;
              ce_q    <= 1'b0;
              prog_q  <= 1'b0;
              we_q    <= 1'b0;
              mode_q  <= MODE_OFF;
              addr_q  <= '0;
              word_q  <= '0;
              idx_q   <= start_idx;
              left_q  <= word_cnt;
              state_q <= ST_INIT;
            end
          end
        end
        ST_INIT: begin
          mode_q  <= MODE_PROGRAM;
          state_q <= ST_MSET;
        end
        ST_MSET: begin
          if (phase_end) begin
            ce_q    <= 1'b1;
            state_q <= ST_PEN;
          end
        end
        ST_PEN: begin
          prog_q  <= 1'b1;
          state_q <= ST_WORD;
        end
        ST_WORD: begin
          if (word_take) begin
            word_q  <= data_word;
            addr_q  <= idx_q;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (phase_end) begin
            we_q    <= 1'b1;
            state_q <= ST_PULSE;
          end
        end
        ST_PULSE: begin
          if (phase_end) begin
            we_q    <= 1'b0;
            state_q <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (phase_end) begin
            if (last_pulse) begin
              idx_q  <= idx_q + 1'b1;
              left_q <= left_q - 1'b1;
              if (left_q == CNT_W'(1)) begin
                prog_q  <= 1'b0;
                state_q <= ST_SH_CE;
              end else begin
                state_q <= ST_WORD;
              end
            end else begin
              state_q <= ST_SETUP;
            end
          end
        end
        ST_SH_CE: begin
          ce_q    <= 1'b0;
          state_q <= ST_SH_MODE;
        end
        ST_SH_MODE: begin
          mode_q  <= MODE_OFF;
          state_q <= ST_SH_TRIM;
        end
        ST_SH_TRIM: begin
          trim_q  <= 1'b0;
          state_q <= ST_SH_DSTB;
        end
        ST_SH_DSTB: begin
          dstb_q  <= 1'b0;
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;
  assign fz_dstb   = dstb_q;
  assign fz_trim   = trim_q;
  assign fz_ce     = ce_q;
  assign fz_prog   = prog_q;
  assign fz_mode   = mode_q;
  assign fz_clk    = 1'b0;
  assign fz_addr   = addr_q;
  assign fz_red    = pass_q;
  assign fz_bitsel = bit_idx;
  assign fz_din    = word_q[bit_idx];
  assign fz_we     = we_q;

endmodule

// File: rtl/otp_burn_chk.sv
module otp_burn_chk #(
  parameter int IDX_W     = 12,
  parameter int WORD_W    = 32,
  parameter int PULSE_CYC = 2500,
  parameter int BIT_W     = $clog2(WORD_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             data_ready,
  input logic             word_take,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             fz_dstb,
  input logic             fz_trim,
  input logic             fz_ce,
  input logic             fz_prog,
  input logic [1:0]       fz_mode,
  input logic [IDX_W-1:0] fz_addr,
  input logic             fz_red,
  input logic [BIT_W-1:0] fz_bitsel,
  input logic             fz_din,
  input logic             fz_we
);

  localparam int HW = $clog2(PULSE_CYC + 2);
  localparam int PW = $clog2(2 * WORD_W + 2);

  logic [HW-1:0] hi_cnt;
  logic [PW-1:0] word_pulses;
  logic          we_d;
  logic          took_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt      <= '0;
      word_pulses <= '0;
      we_d        <= 1'b0;
      took_any    <= 1'b0;
    end else begin
      hi_cnt <= fz_we ? hi_cnt + 1'b1 : '0;
      we_d   <= fz_we;
      if (word_take) begin
        word_pulses <= '0;
        took_any    <= 1'b1;
      end else if (fz_we && !we_d) begin
        word_pulses <= word_pulses + 1'b1;
      end
    end
  end

  p_we_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fz_we |-> (fz_prog && fz_ce && fz_dstb && fz_trim && fz_mode == 2'd2));

  p_init_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fz_dstb) |-> (fz_trim && !fz_ce && !fz_prog && fz_mode == 2'd0));

  p_ready_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> (!fz_we && !fz_red && fz_prog));

  p_word_pulses_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_take && took_any) |-> (word_pulses == PW'(2 * WORD_W)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fz_we && $past(fz_we)) |->
      ($stable(fz_bitsel) && $stable(fz_din) && $stable(fz_addr) && $stable(fz_red)));

  p_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fz_we) |-> (hi_cnt == HW'(PULSE_CYC)));

  p_err_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !fz_dstb));

  p_shut_ce_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fz_ce) |-> (!fz_prog && !fz_we));

  p_shut_dstb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fz_dstb) |-> (done && !fz_trim && !fz_ce && fz_mode == 2'd0));

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind otp_burn_seq otp_burn_chk #(
  .IDX_W     (IDX_W),
  .WORD_W    (WORD_W),
  .PULSE_CYC (PULSE_CYC),
  .BIT_W     (BIT_W)
) u_burn_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .data_ready (data_ready),
  .word_take  (word_take),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .fz_dstb    (fz_dstb),
  .fz_trim    (fz_trim),
  .fz_ce      (fz_ce),
  .fz_prog    (fz_prog),
  .fz_mode    (fz_mode),
  .fz_addr    (fz_addr),
  .fz_red     (fz_red),
  .fz_bitsel  (fz_bitsel),
  .fz_din     (fz_din),
  .fz_we      (fz_we)
);

// File: tb/test_otp_burn_seq.sv
`timescale 1ns/1ps
module test_otp_burn_seq;

  localparam int IW  = 6;
  localparam int TOT = 40;
  localparam int WW  = 32;
  localparam int BW  = 5;
  localparam int MS  = 3;
  localparam int ASU = 2;
  localparam int PWC = 4;
  localparam int GAP = 2;
  localparam int PER_WORD = 2 * WW;
  localparam int WD_LIMIT = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [IW-1:0] start_idx = '0;
  logic [IW:0]   word_cnt = '0;
  logic          data_valid = 1'b0;
  logic [WW-1:0] data_word = '0;
  logic          data_ready, busy, done, err;
  logic          fz_dstb, fz_trim, fz_ce, fz_prog, fz_clk, fz_red, fz_din, fz_we;
  logic [1:0]    fz_mode;
  logic [IW-1:0] fz_addr;
  logic [BW-1:0] fz_bitsel;

  otp_burn_seq #(
    .IDX_W(IW), .TOTAL_WORDS(TOT), .WORD_W(WW),
    .MODE_SETUP_CYC(MS), .ADDR_SETUP_CYC(ASU), .PULSE_CYC(PWC), .GAP_CYC(GAP)
  ) i_otp_burn_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_idx(start_idx),
    .word_cnt(word_cnt), .data_valid(data_valid), .data_word(data_word),
    .data_ready(data_ready), .busy(busy), .done(done), .err(err),
    .fz_dstb(fz_dstb), .fz_trim(fz_trim), .fz_ce(fz_ce), .fz_prog(fz_prog),
    .fz_mode(fz_mode), .fz_clk(fz_clk), .fz_addr(fz_addr), .fz_red(fz_red),
    .fz_bitsel(fz_bitsel), .fz_din(fz_din), .fz_we(fz_we)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int pulse_n = 0;
  int took = 0;
  int req_start = 0;
  int req_cnt = 0;
  bit in_run = 1'b0;
  int clk_bad = 0;
  logic [WW-1:0] words [0:3];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit exp_reject(input int s, input int c);
    // run rejected when it starts past the last index or runs off the end
    return (s > TOT - 1) || (s + c > TOT);
  endfunction

  function automatic int exp_bit(input int p);
    return p % WW;
  endfunction

  function automatic int exp_red(input int p);
    return (p % PER_WORD) >= WW ? 1 : 0;
  endfunction

  // passive monitor
  logic [IW+BW+1:0] prev_sig = '0;
  int stable_n = 0;
  int t_dstb = 0, t_mode = 0, t_ce = 0, t_rise = 0, t_fall = 0, t_pfall = 0;
  logic p_dstb = 0, p_trim = 0, p_ce = 0, p_prog = 0, p_we = 0;
  logic [1:0] p_mode = 0;

  always @(negedge clk) begin
    logic [IW+BW+1:0] sig;
    cyc++;
    if (cyc > WD_LIMIT) begin
      chk(1'b0, "watchdog", cyc, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rst_n) begin
      sig = {fz_addr, fz_red, fz_bitsel, fz_din};
      if (sig != prev_sig) stable_n = 1; else stable_n++;
      prev_sig = sig;
      if (fz_clk) clk_bad++;
      if (err && in_run) chk(1'b0, "R11 err during run", 1, 0);
      if (fz_dstb && !p_dstb) begin
        t_dstb = cyc;
        chk(fz_trim && fz_mode == 0 && !fz_ce && !fz_prog && !fz_we && fz_addr == 0 &&
            !fz_red && fz_bitsel == 0 && !fz_din, "R3 init pins", sig, 0);
      end
      if (fz_mode == 2 && p_mode == 0) begin
        t_mode = cyc;
        chk(cyc == t_dstb + 1, "R3 mode after wake", cyc - t_dstb, 1);
      end
      if (fz_ce && !p_ce) begin
        t_ce = cyc;
        chk(cyc == t_mode + MS && fz_mode == 2, "R4 mode setup", cyc - t_mode, MS);
      end
      if (fz_prog && !p_prog) chk(cyc == t_ce + 1, "R4 prog after ce", cyc - t_ce, 1);
      if (fz_we && !p_we) begin
        int k, b;
        k = pulse_n / PER_WORD;
        b = exp_bit(pulse_n);
        chk(int'(fz_addr) == req_start + k, "R5 addr", fz_addr, req_start + k);
        chk(int'(fz_red) == exp_red(pulse_n), "R5 red", fz_red, exp_red(pulse_n));
        chk(int'(fz_bitsel) == b, "R6 bitsel", fz_bitsel, b);
        if (k < 4) chk(fz_din == words[k][b], "R6 din", fz_din, words[k][b]);
        if (pulse_n % PER_WORD != 0) begin
          chk(stable_n == ASU + 1, "R7 setup", stable_n, ASU + 1);
          chk(cyc - t_fall == GAP + ASU, "R8 low time", cyc - t_fall, GAP + ASU);
        end else begin
          chk(stable_n >= ASU + 1, "R7 first setup", stable_n, ASU + 1);
        end
        t_rise = cyc;
        pulse_n++;
      end
      if (!fz_we && p_we) begin
        t_fall = cyc;
        chk(cyc - t_rise == PWC, "R8 high time", cyc - t_rise, PWC);
      end
      if (!fz_prog && p_prog) begin
        t_pfall = cyc;
        chk(cyc - t_fall == GAP, "R10 prog drop", cyc - t_fall, GAP);
        chk(pulse_n == PER_WORD * req_cnt, "R5 strobe total", pulse_n, PER_WORD * req_cnt);
        chk(!fz_red, "R5 red back low", fz_red, 0);
      end
      if (!fz_ce && p_ce) chk(cyc == t_pfall + 1, "R10 ce drop", cyc - t_pfall, 1);
      if (fz_mode == 0 && p_mode != 0) chk(cyc == t_pfall + 2, "R10 mode drop", cyc - t_pfall, 2);
      if (!fz_trim && p_trim) chk(cyc == t_pfall + 3, "R10 trim drop", cyc - t_pfall, 3);
      if (!fz_dstb && p_dstb) begin
        chk(cyc == t_pfall + 4, "R10 wake drop", cyc - t_pfall, 4);
        chk(done && !busy, "R10 done at last drop", {done, busy}, 2);
      end
      p_dstb = fz_dstb; p_trim = fz_trim; p_ce = fz_ce; p_prog = fz_prog;
      p_we = fz_we; p_mode = fz_mode;
    end
  end

  // word handshake: counted at the edge where it takes effect
  always @(posedge clk) begin
    if (rst_n && data_valid && data_ready) begin
      chk(pulse_n == PER_WORD * took && !fz_we, "R9 word after strobes", pulse_n, PER_WORD * took);
      took++;
    end
  end

  task automatic run_req(input int s, input int c, input bit poke);
    bit rej;
    int act;
    rej = exp_reject(s, c);
    req_start = s;
    req_cnt = c;
    pulse_n = 0;
    took = 0;
    for (int k = 0; k < 4; k++) words[k] = $urandom;
    @(negedge clk);
    start_i = 1'b1;
    start_idx = IW'(s);
    word_cnt = (IW+1)'(c);
    @(negedge clk);
    start_i = 1'b0;
    if (rej) begin
      chk(err && !busy && !fz_dstb, "R1 reject", {err, busy, fz_dstb}, 4);
      act = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (err || busy || fz_dstb || fz_ce || fz_we) act++;
      end
      chk(act == 0, "R1 no activity", act, 0);
    end else if (c == 0) begin
      chk(done && !busy && !err, "R2 empty run", {done, busy, err}, 4);
      act = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (done || busy || fz_dstb || fz_we) act++;
      end
      chk(act == 0, "R2 no activity", act, 0);
    end else begin
      in_run = 1'b1;
      chk(busy && fz_dstb && fz_trim, "R11 busy after start", {busy, fz_dstb, fz_trim}, 7);
      for (int k = 0; k < c; k++) begin
        repeat ($urandom_range(0, 5)) @(negedge clk);
        data_valid = 1'b1;
        data_word = words[k];
        while (!data_ready) @(negedge clk);
        @(negedge clk);
        data_valid = 1'b0;
        data_word = $urandom;
        if (poke && k == 0) begin
          start_i = 1'b1;
          start_idx = IW'(TOT + 3);
          word_cnt = '0;
          @(negedge clk);
          start_i = 1'b0;
          chk(busy && !err && !done, "R11 start ignored", {busy, err, done}, 4);
        end
      end
      while (!done) @(negedge clk);
      chk(!busy && pulse_n == PER_WORD * c, "R11 busy cleared at done", pulse_n, PER_WORD * c);
      in_run = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && !data_ready && !fz_dstb && !fz_trim && !fz_ce &&
        !fz_prog && fz_mode == 0 && !fz_clk && fz_addr == 0 && !fz_red &&
        fz_bitsel == 0 && !fz_din && !fz_we, "R12 reset state", 1, 0);

    run_req(0, 1, 1'b0);          // first index, single word
    run_req(TOT - 2, 2, 1'b1);    // ends on last index, stray start mid-run
    run_req(TOT - 1, 2, 1'b0);    // overruns by one
    run_req(TOT, 0, 1'b0);        // start past the end
    run_req(5, 0, 1'b0);          // zero-length run
    run_req(TOT - 1, 1, 1'b0);    // last index alone
    for (int i = 0; i < 10; i++) begin
      run_req($urandom_range(0, TOT + 1), $urandom_range(0, 3), i[0]);
    end
    repeat (4) @(negedge clk);
    chk(clk_bad == 0, "R12 array clock low", clk_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule